// File: doc/BRIEF.md
# Hard Trap Arbiter with Conflict Reset

This block sits beside a processor core and takes in four non-maskable hard trap events, each with a fixed rank: oscillator failure ranks highest, then address error, then stack error, and math error ranks lowest. Every trap moves through its own life cycle. It becomes pending when it is detected and acknowledged when the core takes its vector. One cycle later it is in service, and it stays there until the core reports that its handler has returned. While any trap waits for its acknowledge, the core is stalled and a vector request names the highest-ranked waiting trap. The request also gives the vector table slot for that trap.

A higher-ranked trap may arrive while a lower-ranked one is outstanding, and it then nests. A lower-ranked trap that arrives while a higher-ranked one is pending, acknowledged or in service is a conflict. A lower-ranked trap that arrives in the same cycle as a higher-ranked one is also a conflict. The block does not queue it. Instead it drops every trap, drives a system reset pulse of fixed length and latches a cause flag. That flag survives the pulse. Only a software clear or the power-on reset removes it. An elevated priority bit tells the core that trap code, not ordinary interrupt code, is running.

Top module: `hard_trap_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, all traps return to idle and the cause flag is cleared. After that edge every output is 0, except `vec_slot`, which reads 2.
- R2: The trap encoding is bit 0 = oscillator fail, bit 1 = address error, bit 2 = stack error, bit 3 = math error. An event on an idle trap that causes no conflict makes that trap pending from the next cycle. `vec_req` and `cpu_stall` are then high, `vec_idx` holds the trap's bit number, and `vec_slot` is 2 plus that number.
- R3: When several traps are pending, `vec_idx` names the lowest bit number. A higher-ranked event during a lower-ranked outstanding trap nests and raises no conflict.
- R4: `trap_ack` moves the trap named by `vec_idx` to acknowledged. `cpu_stall` and `vec_req` stay high as long as any trap is pending. `trap_ack` with nothing pending has no effect.
- R5: An acknowledged trap enters service one cycle later. `ipl_hi` is high exactly while at least one trap is in service. `trap_done` returns the highest-ranked trap in service to idle, and it has no effect when no trap is in service.
- R6: A conflict is an event on a trap while a higher-ranked trap is outstanding, or while a higher-ranked event arrives in the same cycle. A conflict clears all traps and drives `conflict_rst` high for exactly 4 cycles, starting in the next cycle.
- R7: A conflict sets `cause_flag`, and the flag stays set through the reset pulse. `cause_clr` clears it, but a conflict in the same cycle wins. `rst` also clears it.
- R8: Trap events that arrive while `conflict_rst` is high are ignored.
- R9: A repeated event on a trap that is already outstanding, with no higher-ranked trap outstanding, is ignored and leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| trap_evt | input | 4 | Trap event strobes, bit 0 ranked highest |
| trap_ack | input | 1 | Core has taken the requested vector |
| trap_done | input | 1 | Innermost trap handler has returned |
| cause_clr | input | 1 | Software clear of the cause flag |
| vec_req | output | 1 | A trap vector is requested |
| vec_idx | output | 2 | Bit number of the requested trap |
| vec_slot | output | 7 | Vector table slot of the requested trap |
| cpu_stall | output | 1 | Hold instruction execution until acknowledge |
| ipl_hi | output | 1 | Elevated priority bit, high while a trap is in service |
| conflict_rst | output | 1 | System reset pulse after a conflict |
| cause_flag | output | 1 | Sticky conflict-reset cause bit |

## Verification
The assertions assume that the core raises `trap_ack` only in a cycle in which it can see `vec_req`. They also assume that `trap_done` pairs with a trap in service. Stray strobes are legal, but the checks that relate acknowledge to service rely on the arbiter's own decode to ignore them. The stimulus keeps `rst` high for several cycles at the start, so that no property sees pre-reset state. The stimulus is a directed sequence followed by a sparse pseudo-random phase. In that phase the event probabilities are low, so that nesting, acknowledge chains and conflicts all occur, and a reference model that tracks each trap as an integer state is compared on every cycle.

// File: rtl/hta_pkg.sv
package hta_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_PEND = 2'd1,
    TS_ACKD = 2'd2,
    TS_SERV = 2'd3
  } trap_st_e;
endpackage

// File: rtl/hta_pick.sv
// Fixed-rank picker: lowest bit index wins.
module hta_pick #(
  parameter int N     = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     sel
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
    any = |req;
    sel = '0;
    if (any) sel[idx] = 1'b1;
  end
endmodule

// File: rtl/hta_slot.sv
// Life cycle of one trap: idle, pending, acknowledged, in service.
module hta_slot
  import hta_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     flush,
  input  logic     take,
  input  logic     ack_sel,
  input  logic     done_sel,
  output trap_st_e st
);
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      st <= TS_IDLE;
    end else begin
      case (st)
        TS_IDLE: if (take)     st <= TS_PEND;
        TS_PEND: if (ack_sel)  st <= TS_ACKD;
        TS_ACKD:               st <= TS_SERV;
        TS_SERV: if (done_sel) st <= TS_IDLE;
        default:               st <= TS_IDLE;
      endcase
    end
  end

  // R5: acknowledged lasts one cycle, then service
  a_r5_ack_to_serv: assert property (@(posedge clk) disable iff (rst)
    (st == TS_ACKD && !flush) |=> (st == TS_SERV));

  // R4: a pending trap only leaves through acknowledge or flush
  a_r4_pend_hold: assert property (@(posedge clk) disable iff (rst)
    (st == TS_PEND && !ack_sel && !flush) |=> (st == TS_PEND));
endmodule

// File: rtl/hta_rstgen.sv
// Conflict reset pulse timer and sticky cause flag.
module hta_rstgen #(
  parameter int RST_CYCLES = 4,
  localparam int CNT_W = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic conflict,
  input  logic cause_clr,
  output logic rst_act,
  output logic cause_flag
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (conflict) begin
      cnt <= CNT_W'(RST_CYCLES);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            cause_flag <= 1'b0;
    else if (conflict)  cause_flag <= 1'b1;
    else if (cause_clr) cause_flag <= 1'b0;
  end

  assign rst_act = (cnt != '0);

  // R6: counter never exceeds the pulse length
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(RST_CYCLES));

  // R6: once running, the pulse counts down one per cycle
  a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !conflict) |=> (cnt == $past(cnt) - 1'b1));

  // R7: flag is set when the pulse starts
  a_r7_flag_on_pulse: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_act) |-> cause_flag);
endmodule

// File: rtl/hard_trap_arbiter.sv
module hard_trap_arbiter
  import hta_pkg::*;
#(
  parameter int N_TRAPS    = 4,
  parameter int RST_CYCLES = 4,
  parameter int SLOT_W     = 7,
  parameter int SLOT_BASE  = 2,
  localparam int IDX_W     = (N_TRAPS > 1) ? $clog2(N_TRAPS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_TRAPS-1:0] trap_evt,
  input  logic               trap_ack,
  input  logic               trap_done,
  input  logic               cause_clr,
  output logic               vec_req,
  output logic [IDX_W-1:0]   vec_idx,
  output logic [SLOT_W-1:0]  vec_slot,
  output logic               cpu_stall,
  output logic               ipl_hi,
  output logic               conflict_rst,
  output logic               cause_flag
);
  trap_st_e           st [N_TRAPS];
  logic [N_TRAPS-1:0] busy, pend, ackd, serv, hi_busy;
  logic [N_TRAPS-1:0] pend_sel, serv_sel;
  logic [IDX_W-1:0]   serv_idx;
  logic               pend_any, serv_any;
  logic               conflict, rst_act, flush;

  always_comb begin
    for (int i = 0; i < N_TRAPS; i++) begin
      busy[i] = (st[i] != TS_IDLE);
      pend[i] = (st[i] == TS_PEND);
      ackd[i] = (st[i] == TS_ACKD);
      serv[i] = (st[i] == TS_SERV);
    end
  end

  // A higher-ranked trap is busy or arriving now
  always_comb begin
    logic run;
    run = 1'b0;
    for (int i = 0; i < N_TRAPS; i++) begin
      hi_busy[i] = run;
      run = run | busy[i] | trap_evt[i];
    end
  end

  assign conflict = !rst_act && |(trap_evt & hi_busy);
  assign flush    = conflict | rst_act;

  hta_pick #(.N(N_TRAPS)) i_pend_pick (
    .req(pend), .any(pend_any), .idx(vec_idx), .sel(pend_sel)
  );

  hta_pick #(.N(N_TRAPS)) i_serv_pick (
    .req(serv), .any(serv_any), .idx(serv_idx), .sel(serv_sel)
  );

  for (genvar g = 0; g < N_TRAPS; g++) begin : g_slot
    hta_slot i_slot (
      .clk      (clk),
      .rst      (rst),
      .flush    (flush),
      .take     (trap_evt[g]),
      .ack_sel  (trap_ack & pend_sel[g]),
      .done_sel (trap_done & serv_sel[g]),
      .st       (st[g])
    );
  end

  hta_rstgen #(.RST_CYCLES(RST_CYCLES)) i_rstgen (
    .clk        (clk),
    .rst        (rst),
    .conflict   (conflict),
    .cause_clr  (cause_clr),
    .rst_act    (rst_act),
    .cause_flag (cause_flag)
  );

  assign vec_req      = pend_any;
  assign cpu_stall    = pend_any;
  assign vec_slot     = SLOT_W'(SLOT_BASE) + SLOT_W'(vec_idx);
  assign ipl_hi       = serv_any;
  assign conflict_rst = rst_act;

  // R6: nothing outstanding while the reset pulse runs
  a_r6_pulse_clean: assert property (@(posedge clk) disable iff (rst)
    conflict_rst |-> (!vec_req && !ipl_hi && busy == '0));

  // R3: the requested trap really is pending
  a_r3_req_pending: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> (st[vec_idx] == TS_PEND));

  // R4: at most one trap is acknowledged per cycle
  a_r4_one_ackd: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ackd));

  // R5: retirement picks the highest-ranked in-service trap
  a_r5_serv_pick: assert property (@(posedge clk) disable iff (rst)
    ipl_hi |-> (st[serv_idx] == TS_SERV));
endmodule

// File: tb/test_hard_trap_arbiter.sv
module test_hard_trap_arbiter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] trap_evt = '0;
  logic       trap_ack = 1'b0, trap_done = 1'b0, cause_clr = 1'b0;
  logic       vec_req, cpu_stall, ipl_hi, conflict_rst, cause_flag;
  logic [1:0] vec_idx;
  logic [6:0] vec_slot;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hard_trap_arbiter i_hard_trap_arbiter (
    .clk(clk), .rst(rst), .trap_evt(trap_evt), .trap_ack(trap_ack),
    .trap_done(trap_done), .cause_clr(cause_clr), .vec_req(vec_req),
    .vec_idx(vec_idx), .vec_slot(vec_slot), .cpu_stall(cpu_stall),
    .ipl_hi(ipl_hi), .conflict_rst(conflict_rst), .cause_flag(cause_flag)
  );

  // Behavioural model: 0 idle, 1 pending, 2 acknowledged, 3 in service
  int m_st [4];
  int m_cnt = 0;
  int m_flag = 0;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_st[i]) m_st[i] = 0;
      m_cnt = 0; m_flag = 0;
    end else if (m_cnt > 0) begin
      foreach (m_st[i]) m_st[i] = 0;
      m_cnt--;
      if (cause_clr) m_flag = 0;
    end else begin
      int p, s; bit conf, seen;
      conf = 0; seen = 0;
      for (int i = 0; i < 4; i++) begin
        if (trap_evt[i] && seen) conf = 1;
        if (m_st[i] != 0 || trap_evt[i]) seen = 1;
      end
      if (conf) begin
        foreach (m_st[i]) m_st[i] = 0;
        m_cnt = 4; m_flag = 1;
      end else begin
        if (cause_clr) m_flag = 0;
        p = -1; s = -1;
        for (int i = 3; i >= 0; i--) begin
          if (m_st[i] == 1) p = i;
          if (m_st[i] == 3) s = i;
        end
        for (int i = 0; i < 4; i++) begin
          case (m_st[i])
            0: if (trap_evt[i]) m_st[i] = 1;
            1: if (trap_ack && p == i) m_st[i] = 2;
            2: m_st[i] = 3;
            3: if (trap_done && s == i) m_st[i] = 0;
            default: m_st[i] = 0;
          endcase
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      int p; bit any_p, any_s;
      p = 0; any_p = 0; any_s = 0;
      for (int i = 3; i >= 0; i--) begin
        if (m_st[i] == 1) begin p = i; any_p = 1; end
        if (m_st[i] == 3) any_s = 1;
      end
      chk(vec_req == any_p,       "R2 vec_req",      vec_req, any_p);
      chk(cpu_stall == any_p,     "R4 cpu_stall",    cpu_stall, any_p);
      chk(vec_idx == 2'(p),       "R3 vec_idx",      vec_idx, p);
      chk(vec_slot == 7'(2 + p),  "R2 vec_slot",     vec_slot, 2 + p);
      chk(ipl_hi == any_s,        "R5 ipl_hi",       ipl_hi, any_s);
      chk(conflict_rst == (m_cnt > 0), "R6 conflict_rst", conflict_rst, m_cnt > 0);
      chk(cause_flag == (m_flag != 0), "R7 cause_flag",   cause_flag, m_flag);
    end
  end

  task automatic cyc(input logic [3:0] e, input logic a, input logic d, input logic c);
    @(negedge clk); #1;
    trap_evt = e; trap_ack = a; trap_done = d; cause_clr = c;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    chk(!vec_req && !ipl_hi && !conflict_rst && !cause_flag && vec_slot == 7'd2,
        "R1 reset outputs", vec_req, 0);
    // R2: address error alone
    cyc(4'b0010, 0, 0, 0);
    cyc(4'b0000, 0, 0, 0);
    chk(vec_req && vec_idx == 2'd1 && vec_slot == 7'd3, "R2 addr pending", vec_slot, 3);
    // R3: oscillator fail nests over it
    cyc(4'b0001, 0, 0, 0);
    cyc(4'b0000, 0, 0, 0);
    chk(vec_idx == 2'd0 && !conflict_rst, "R3 nest osc", vec_idx, 0);
    // R4: acknowledge osc, addr still pending
    cyc(4'b0000, 1, 0, 0);
    cyc(4'b0000, 0, 0, 0);
    chk(vec_req && vec_idx == 2'd1 && !ipl_hi, "R4 ack first", vec_idx, 1);
    cyc(4'b0000, 0, 0, 0);
    chk(ipl_hi, "R5 osc in service", ipl_hi, 1);
    cyc(4'b0000, 1, 0, 0);
    cyc(4'b0000, 0, 0, 0);
    chk(!cpu_stall, "R4 stall drops", cpu_stall, 0);
    // R5: two dones retire both
    cyc(4'b0000, 0, 1, 0);
    cyc(4'b0000, 0, 1, 0);
    cyc(4'b0000, 0, 0, 0);
    chk(!ipl_hi, "R5 all retired", ipl_hi, 1'b0);
    // R4/R5: stray ack and done ignored
    cyc(4'b0000, 1, 1, 0);
    cyc(4'b0000, 0, 0, 0);
    chk(!vec_req && !ipl_hi, "R4 stray strobes", vec_req, 0);
    // R9: repeated stack error event
    cyc(4'b0100, 0, 0, 0);
    cyc(4'b0100, 0, 0, 0);
    cyc(4'b0000, 0, 0, 0);
    chk(vec_idx == 2'd2 && !conflict_rst, "R9 repeat ignored", vec_idx, 2);
    // R6: math error under pending stack error
    cyc(4'b1000, 0, 0, 0);
    cyc(4'b0000, 0, 0, 0);
    chk(conflict_rst && !vec_req && cause_flag, "R6 conflict", conflict_rst, 1);
    // R8: event during pulse ignored
    cyc(4'b0001, 0, 0, 0);
    cyc(4'b0000, 0, 0, 0);
    cyc(4'b0000, 0, 0, 0);
    chk(conflict_rst, "R6 pulse 4th cycle", conflict_rst, 1);
    cyc(4'b0000, 0, 0, 0);
    chk(!conflict_rst && !vec_req, "R8 pulse over, no trap", vec_req, 0);
    chk(cause_flag, "R7 flag survives", cause_flag, 1);
    cyc(4'b0000, 0, 0, 1);
    cyc(4'b0000, 0, 0, 0);
    chk(!cause_flag, "R7 clear", cause_flag, 0);
    // R6/R7: simultaneous events conflict, set beats clear
    cyc(4'b0011, 0, 0, 1);
    cyc(4'b0000, 0, 0, 0);
    chk(conflict_rst && cause_flag, "R7 set wins", cause_flag, 1);
    repeat (6) cyc(4'b0000, 0, 0, 0);
    // Pseudo-random phase
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] e;
      for (int b = 0; b < 4; b++) e[b] = ($urandom_range(0, 19) == 0);
      cyc(e, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
          $urandom_range(0, 31) == 0);
    end
    // R1: reset clears flag
    cyc(4'b0011, 0, 0, 0);
    cyc(4'b0000, 0, 0, 0);
    @(negedge clk); #1 rst = 1'b1;
    @(negedge clk); #1 rst = 1'b0;
    chk(!cause_flag && !conflict_rst, "R1 reset clears flag", cause_flag, 0);
    repeat (2) cyc(4'b0000, 0, 0, 0);
    finish_run();
  end
endmodule